// File: doc/BRIEF.md
# Snoop-unit control and status register file

This block is the software-visible register window of a snoop control unit in a small multicore cluster. It answers a simple 32-bit peripheral bus. Each request carries an address, a write flag, write data and byte enables. The window is 256 bytes, and single-byte, halfword and word accesses are all accepted.

The window holds three real registers:
- A one-bit enable register.
- A read-only configuration word. It reports which cores are present and an encoded core count, both derived from the `NUM_CORES` parameter.
- A writable per-core power status word.

A few offsets are placeholders that read as zero and discard writes. Every other offset is treated as unsupported: the access still completes, and a one-cycle flag reports it.

Every request completes in a fixed time. Ready and read data appear in the cycle after the request is presented, so software and interconnect never stall on this block.

Top module: `snoop_csr_top`

## Requirements
- R1: The enable register at offset 0x00 keeps only bit 0. It loads from write data bit 0 when byte enable 0 is set, and read bits [31:1] are always zero.
- R2: After reset, the enable register and the power status word are zero, and the ready and unsupported outputs are low.
- R3: A read of offset 0x04 returns the core count minus one in bits [1:0] and NUM_CORES ones starting at bit 4. Writes there change nothing.
- R4: The power status word at offset 0x08 reads back the last full-word value written.
- R5: A write whose address falls anywhere in 0x08 to 0x0B updates only the power status byte lanes whose byte enables are set.
- R6: Offsets 0x0C, 0x40 and 0x44 read as zero, ignore writes and are not flagged as unsupported.
- R7: Any offset outside {0x00, 0x04, 0x08, 0x0C, 0x40, 0x44} reads as zero and ignores writes. The access completes with the unsupported flag high for exactly the response cycle.
- R8: Each request gets ready high, with read data, in exactly the cycle after it is presented. Ready is low in cycles that follow no request.
- R9: A NUM_CORES value outside 1 to 4 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | DATA_W | Write data, lane-aligned |
| req_be | input | DATA_W/8 | Byte enables for writes |
| rsp_ready | output | 1 | Response cycle for the previous request |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rsp_unsup | output | 1 | Previous request hit an unsupported offset |

## Verification
Every result is due one clock edge after the request is taken: ready, read data and the unsupported flag all come from a single register stage. Register state written in a cycle is first visible to a read presented in the following cycle. The bench drives a request on a falling edge and samples the response on the next falling edge. It then samples once more, with no request, to confirm that ready and the flag have dropped. Effects of placeholder and unsupported writes are checked by reading the enable and power registers back afterwards.

// File: rtl/snoop_csr_pkg.sv
package snoop_csr_pkg;

  localparam int MAX_CORES = 4;

  // word indices (byte offset / 4) whose meaning software relies on
  localparam int IDX_ENA    = 0;
  localparam int IDX_CFG    = 1;
  localparam int IDX_PWR    = 2;
  localparam int IDX_INVAL  = 3;
  localparam int IDX_FLT_LO = 16;
  localparam int IDX_FLT_HI = 17;

  typedef enum logic [2:0] {
    SEL_ENA,
    SEL_CFG,
    SEL_PWR,
    SEL_RAZ,
    SEL_UNSUP
  } csr_sel_e;

  function automatic logic [31:0] cfg_word(input int n);
    logic [31:0] mask;
    mask = (32'd1 << n) - 32'd1;
    return (mask << 4) | 32'(n - 1);
  endfunction

endpackage

// File: rtl/snoop_csr_decode.sv
module snoop_csr_decode
  import snoop_csr_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] word_idx,
  output csr_sel_e         sel
);

  always_comb begin
    case (word_idx)
      IDX_W'(IDX_ENA):    sel = SEL_ENA;
      IDX_W'(IDX_CFG):    sel = SEL_CFG;
      IDX_W'(IDX_PWR):    sel = SEL_PWR;
      IDX_W'(IDX_INVAL),
      IDX_W'(IDX_FLT_LO),
      IDX_W'(IDX_FLT_HI): sel = SEL_RAZ;
      default:            sel = SEL_UNSUP;
    endcase
  end

endmodule

// File: rtl/snoop_csr_store.sv
module snoop_csr_store
  import snoop_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  csr_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic              ena_q,
  output logic [DATA_W-1:0] pwr_q
);

  logic wr_ena;
  logic wr_pwr;

  assign wr_ena = wr_en && (sel == SEL_ENA) && be[0];
  assign wr_pwr = wr_en && (sel == SEL_PWR);

  always_ff @(posedge clk) begin
    if (rst)         ena_q <= 1'b0;
    else if (wr_ena) ena_q <= wdata[0];
  end

  for (genvar i = 0; i < BE_W; i++) begin : g_pwr_lane
    always_ff @(posedge clk) begin
      if (rst)
        pwr_q[8*i +: 8] <= 8'h00;
      else if (wr_pwr && be[i])
        pwr_q[8*i +: 8] <= wdata[8*i +: 8];
    end
  end

endmodule

// File: rtl/snoop_csr_resp.sv
module snoop_csr_resp
  import snoop_csr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              write,
  input  csr_sel_e          sel,
  input  logic              ena_q,
  input  logic [DATA_W-1:0] pwr_q,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              unsup
);

  localparam logic [DATA_W-1:0] CFG_VAL = DATA_W'(cfg_word(NUM_CORES));

  logic [DATA_W-1:0] mux_d;

  always_comb begin
    case (sel)
      SEL_ENA: mux_d = {{(DATA_W-1){1'b0}}, ena_q};
      SEL_CFG: mux_d = CFG_VAL;
      SEL_PWR: mux_d = pwr_q;
      default: mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      unsup <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= valid;
      unsup <= valid && (sel == SEL_UNSUP);
      rdata <= (valid && !write) ? mux_d : '0;
    end
  end

endmodule

// File: rtl/snoop_csr_top.sv
module snoop_csr_top
  import snoop_csr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  localparam int BE_W     = DATA_W / 8,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_unsup
);

  // R9: reject an illegal core count at elaboration
  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
    $error("snoop_csr_top: NUM_CORES must be 1..%0d", MAX_CORES);
  end

  csr_sel_e          sel;
  logic              ena_q;
  logic [DATA_W-1:0] pwr_q;
  logic              unused_lsb;

  assign unused_lsb = ^req_addr[1:0];

  snoop_csr_decode #(.IDX_W(IDX_W)) decode_i (
    .word_idx (req_addr[ADDR_W-1:2]),
    .sel      (sel)
  );

  snoop_csr_store #(.DATA_W(DATA_W)) store_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (req_valid && req_write),
    .sel   (sel),
    .wdata (req_wdata),
    .be    (req_be),
    .ena_q (ena_q),
    .pwr_q (pwr_q)
  );

  snoop_csr_resp #(.DATA_W(DATA_W), .NUM_CORES(NUM_CORES)) resp_i (
    .clk   (clk),
    .rst   (rst),
    .valid (req_valid),
    .write (req_write),
    .sel   (sel),
    .ena_q (ena_q),
    .pwr_q (pwr_q),
    .ready (rsp_ready),
    .rdata (rsp_rdata),
    .unsup (rsp_unsup)
  );

endmodule

// File: rtl/snoop_csr_chk.sv
module snoop_csr_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_unsup
);

  localparam logic [DATA_W-1:0] CFG_EXP =
    DATA_W'((((1 << NUM_CORES) - 1) << 4) | (NUM_CORES - 1));

  logic rd_ena;
  logic rd_cfg;

  assign rd_ena = req_valid && !req_write && (req_addr[ADDR_W-1:2] == '0);
  assign rd_cfg = req_valid && !req_write &&
                  (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

  a_r8_ready_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_ready);

  a_r8_no_spurious_ready: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_ready);

  a_r7_unsup_with_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_unsup |-> rsp_ready);

  a_r7_unsup_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_unsup |-> (rsp_rdata == '0));

  a_r1_ena_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_ena |=> (rsp_rdata[DATA_W-1:1] == '0));

  a_r3_cfg_value: assert property (@(posedge clk) disable iff (rst)
    rd_cfg |=> (rsp_rdata == CFG_EXP));

endmodule

bind snoop_csr_top snoop_csr_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_unsup (rsp_unsup)
);

// File: tb/snoop_csr_top_tb_top.sv
`timescale 1ns/1ps
module snoop_csr_top_tb_top;

  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr  = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be    = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic        rsp_unsup;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic        ena_m = 1'b0;
  logic [31:0] pwr_m = '0;
  logic [31:0] cfg_m;

  always #2 clk = ~clk;

  snoop_csr_top #(.NUM_CORES(NC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_unsup(rsp_unsup)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit is_known(input int idx);
    return idx == 0 || idx == 1 || idx == 2 || idx == 3 || idx == 16 || idx == 17;
  endfunction

  // one access: response sampled one cycle later, then idle cycle checked
  task automatic access(input bit wr, input logic [7:0] a,
                        input logic [31:0] d, input logic [3:0] be,
                        input bit exp_unsup, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_wdata = d; req_be = be;
    @(negedge clk);
    check("R8 ready", {31'd0, rsp_ready}, 32'd1);
    check("R7 unsup flag", {31'd0, rsp_unsup}, {31'd0, exp_unsup});
    rd = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0; req_be = '0;
    @(negedge clk);
    check("R8 ready drops", {31'd0, rsp_ready}, 32'd0);
    check("R7 flag drops", {31'd0, rsp_unsup}, 32'd0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a,
                        input logic [31:0] exp);
    logic [31:0] v;
    access(1'b0, a, 32'h0, 4'h0, !is_known(int'(a[7:2])), v);
    check(req, v, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] be);
    logic [31:0] v;
    access(1'b1, a, d, be, !is_known(int'(a[7:2])), v);
    check("R8 write rdata zero", v, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_m = ((32'd1 << NC) - 32'd1) << 4 | 32'(NC - 1);
    repeat (3) @(negedge clk);
    // R2: outputs quiet in reset
    check("R2 ready in reset", {31'd0, rsp_ready}, 32'd0);
    check("R2 unsup in reset", {31'd0, rsp_unsup}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 ready after reset", {31'd0, rsp_ready}, 32'd0);
    rd_chk("R2 enable reset", 8'h00, 32'h0);
    rd_chk("R2 power reset", 8'h08, 32'h0);

    // R3 / R9: configuration word for the elaborated core count
    rd_chk("R3 R9 config", 8'h04, cfg_m);
    wr(8'h04, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3 config after write", 8'h04, cfg_m);

    // R1
    wr(8'h00, 32'hFFFF_FFFF, 4'hF); ena_m = 1'b1;
    rd_chk("R1 enable set", 8'h00, 32'h1);
    wr(8'h00, 32'hFFFF_FFFE, 4'hF); ena_m = 1'b0;
    rd_chk("R1 enable clear", 8'h00, 32'h0);
    wr(8'h00, 32'h0000_0001, 4'hE);
    rd_chk("R1 lane0 not enabled", 8'h00, 32'h0);
    wr(8'h00, 32'h0000_0003, 4'h1); ena_m = 1'b1;
    rd_chk("R1 byte write", 8'h00, 32'h1);

    // R4
    wr(8'h08, 32'hA5C3_1E7F, 4'hF); pwr_m = 32'hA5C3_1E7F;
    rd_chk("R4 power full", 8'h08, pwr_m);
    wr(8'h08, 32'h0000_0000, 4'hF); pwr_m = 32'h0;
    rd_chk("R4 power clear", 8'h08, pwr_m);

    // R5: every byte lane, through its own byte address
    for (int i = 0; i < 4; i++) begin
      logic [31:0] d;
      d = 32'(8'h11 * (i + 1)) << (8 * i);
      wr(8'(8 + i), d | ~(32'hFF << (8 * i)), 4'(1 << i));
      pwr_m[8*i +: 8] = d[8*i +: 8];
      rd_chk("R5 byte lane", 8'h08, pwr_m);
    end
    wr(8'h0A, 32'h5A6B_0000, 4'hC); pwr_m[31:16] = 16'h5A6B;
    rd_chk("R5 upper half", 8'h08, pwr_m);
    wr(8'h08, 32'hFFFF_7788, 4'h3); pwr_m[15:0] = 16'h7788;
    rd_chk("R5 lower half", 8'h08, pwr_m);

    // R6 / R7: sweep every word of the window
    for (int idx = 0; idx < 64; idx++) begin
      logic [31:0] e;
      case (idx)
        0: e = {31'd0, ena_m};
        1: e = cfg_m;
        2: e = pwr_m;
        default: e = 32'h0;
      endcase
      rd_chk(is_known(idx) ? "R6 sweep read" : "R7 sweep read",
             8'(idx * 4), e);
      if (idx != 0 && idx != 2) begin
        wr(8'(idx * 4 + (idx % 4)), 32'hFFFF_FFFF, 4'hF);
        rd_chk("R7 R6 enable untouched", 8'h00, {31'd0, ena_m});
        rd_chk("R7 R6 power untouched", 8'h08, pwr_m);
        rd_chk(is_known(idx) ? "R6 reads zero" : "R7 reads zero",
               8'(idx * 4), (idx == 1) ? cfg_m : 32'h0);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule